// File: doc/BRIEF.md
# Nth-Chance Clock Page-Frame Victim Selector

This block chooses which physical page frame to give up when a page fault needs room, for a small memory of `NUM_FRAMES` frames. For every frame it keeps a valid bit, a use bit, a dirty bit and a small sweep counter. A single circular hand points at one frame. Normal memory traffic reports each reference through the reference port: the frame's use bit is set, and a write also marks it dirty. The hand does not move in real time. It only advances while a fault is being serviced.

On a fault request the block first looks for a frame that has never been loaded. If there is one, it returns the lowest-numbered such frame at once. If every frame is valid, the block sweeps from the hand, one frame per clock. A frame whose use bit is set loses that bit and its sweep counter, and is passed over. A frame whose use bit is clear has its counter incremented. It becomes the victim once the counter reaches its threshold: `CLEAN_CHANCES` for a clean frame and `DIRTY_CHANCES` for a dirty one, so a dirty page survives one sweep more. The result carries the frame index and a flag telling the caller that the old contents must be written back. After a dirty victim the block waits for a write-back acknowledge, then clears that frame's dirty bit. When the caller has filled a frame, it reports this on the load-complete input. That makes the frame valid, sets its use bit, and clears its dirty bit and counter.

The controller has four states. `ST_IDLE` waits for a request: a fault with a free frame goes to `ST_REPORT`, and a fault with no free frame goes to `ST_SCAN`. `ST_SCAN` examines the frame under the hand each cycle and goes to `ST_REPORT` on the cycle it selects a victim. `ST_REPORT` drives the result. When the result is accepted, it goes to `ST_WB_WAIT` if the write-back flag is set and to `ST_IDLE` otherwise. `ST_WB_WAIT` returns to `ST_IDLE` on the write-back acknowledge.

Top module: `clock_victim_picker`

## Requirements
- R1: After reset no result is offered (`res_valid`=0), every frame is invalid, the hand is at frame 0, and all use bits, dirty bits and counters are 0.
- R2: A fault accepted in `ST_IDLE` while any frame is invalid returns the lowest-numbered invalid frame with `res_writeback`=0. The result appears one cycle after the request and the hand does not move.
- R3: A load-complete pulse for frame f sets f valid, sets its use bit, and clears its dirty bit and counter. A write reference to f in the same cycle still marks it dirty.
- R4: A reference sets the use bit of the referenced frame. A reference with `ref_write`=1 also sets its dirty bit.
- R5: During a search the hand examines exactly one frame per cycle and advances circularly (frame `NUM_FRAMES`-1 is followed by 0). A frame with its use bit set gets its use bit and counter cleared and is passed over. The hand never moves outside a search.
- R6: A frame with its use bit clear has its counter incremented. It is chosen when the counter reaches 1 if clean or 2 if dirty (the defaults of `CLEAN_CHANCES` and `DIRTY_CHANCES`). Its counter is then cleared and the hand moves to the frame after it.
- R7: `res_writeback` equals the victim's dirty bit at selection. After a dirty victim is accepted, no new fault is taken until `wb_ack`. `wb_ack` then clears that frame's dirty bit.
- R8: While `res_valid`=1 and `res_ready`=0, `res_valid`, `res_frame` and `res_writeback` hold steady. The result is dropped on the cycle after it is accepted.
- R9: If a reference and a search clear hit the same frame in one cycle, the frame's use bit ends up 1.
- R10: With no references or loads during a search, a search lasts at most (`DIRTY_CHANCES`+1)×`NUM_FRAMES`+1 cycles. The result latency equals the number of frames examined plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A frame was referenced this cycle |
| ref_frame | input | IDX_W | Index of the referenced frame |
| ref_write | input | 1 | The reference was a write |
| load_valid | input | 1 | A frame finished loading this cycle |
| load_frame | input | IDX_W | Index of the loaded frame |
| fault_req | input | 1 | Request a victim; sampled only in `ST_IDLE` |
| res_valid | output | 1 | Victim result is offered |
| res_ready | input | 1 | Consumer accepts the result |
| res_frame | output | IDX_W | Chosen frame index |
| res_writeback | output | 1 | Old contents of the chosen frame must be written back |
| wb_ack | input | 1 | Write-back of the last dirty victim finished |

## Verification
On every cycle the assertions check the following:
- a reference or a load leaves its frame with the use bit set, even against a same-cycle clear;
- no sweep counter passes the dirty threshold;
- the hand stays put outside `ST_SCAN`;
- an offered result stays stable until it is accepted;
- an acknowledged write-back clears the victim's dirty bit;
- a quiet search ends within its bound.

Which frame is picked depends on the history of references, and only the bench scenarios can show that. These are directed sequences whose victim and latency are computed by hand:
- free frames are used first, in order;
- a fully referenced memory is swept once and wraps around;
- a dirty frame outlives a clean one;
- the dirty bit is gone after the acknowledge;
- a reference that meets the sweep on the same frame wins.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_REPORT,
        ST_WB_WAIT
    } pick_state_e;

    // Bits needed to hold a counter value 0..lim
    function automatic int cnt_bits(input int lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/free_slot_pick.sv
module free_slot_pick #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3
) (
    input  logic [NUM_FRAMES-1:0] valid_vec,
    output logic                  any_free,
    output logic [IDX_W-1:0]      free_idx
);

    // Scan from the top so that the lowest invalid frame wins
    always_comb begin
        free_idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign any_free = ~&valid_vec;

endmodule

// File: rtl/frame_meta_bank.sv
module frame_meta_bank #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = 3,
    parameter int CNT_W      = 2,
    parameter int CNT_MAX    = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ref_valid,
    input  logic [IDX_W-1:0]                 ref_frame,
    input  logic                             ref_write,
    input  logic                             load_valid,
    input  logic [IDX_W-1:0]                 load_frame,
    input  logic                             exam_en,
    input  logic [IDX_W-1:0]                 exam_frame,
    input  logic                             exam_clear,
    input  logic                             exam_inc,
    input  logic                             exam_zero,
    input  logic                             dclr_en,
    input  logic [IDX_W-1:0]                 dclr_frame,
    output logic [NUM_FRAMES-1:0]            valid_vec,
    output logic [NUM_FRAMES-1:0]            use_vec,
    output logic [NUM_FRAMES-1:0]            dirty_vec,
    output logic [NUM_FRAMES-1:0][CNT_W-1:0] cnt_vec
);

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
        logic             ref_hit, load_hit, exam_hit, dclr_hit;
        logic             valid_q, use_q, dirty_q;
        logic [CNT_W-1:0] cnt_q;

        assign ref_hit  = ref_valid  && (ref_frame  == IDX_W'(i));
        assign load_hit = load_valid && (load_frame == IDX_W'(i));
        assign exam_hit = exam_en    && (exam_frame == IDX_W'(i));
        assign dclr_hit = dclr_en    && (dclr_frame == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                use_q   <= 1'b0;
                dirty_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                if (load_hit) begin
                    valid_q <= 1'b1;
                end
                // A reference or load beats a sweep clear
                if (ref_hit || load_hit) begin
                    use_q <= 1'b1;
                end else if (exam_hit && exam_clear) begin
                    use_q <= 1'b0;
                end
                // A write reference beats load and write-back clears
                if (ref_hit && ref_write) begin
                    dirty_q <= 1'b1;
                end else if (load_hit || dclr_hit) begin
                    dirty_q <= 1'b0;
                end
                if (load_hit) begin
                    cnt_q <= '0;
                end else if (exam_hit) begin
                    if (exam_clear || exam_zero) begin
                        cnt_q <= '0;
                    end else if (exam_inc) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end

        assign valid_vec[i] = valid_q;
        assign use_vec[i]   = use_q;
        assign dirty_vec[i] = dirty_q;
        assign cnt_vec[i]   = cnt_q;

        AST_CNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_W'(CNT_MAX)) else $error("sweep counter above limit"); // R6
    end

    AST_REF_SETS_USE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> use_vec[$past(ref_frame)]) else $error("reference lost"); // R9

    AST_LOAD_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !(ref_valid && ref_write && ref_frame == load_frame))
        |=> (valid_vec[$past(load_frame)] && use_vec[$past(load_frame)] &&
             !dirty_vec[$past(load_frame)] && cnt_vec[$past(load_frame)] == '0))
        else $error("load did not reset frame"); // R3

endmodule

// File: rtl/clock_victim_picker.sv
module clock_victim_picker
    import clock_victim_pkg::*;
#(
    parameter int  NUM_FRAMES    = 8,
    parameter int  CLEAN_CHANCES = 1,
    parameter int  DIRTY_CHANCES = 2,
    localparam int IDX_W         = (NUM_FRAMES < 2) ? 1 : $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             ref_write,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_frame,
    input  logic             fault_req,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [IDX_W-1:0] res_frame,
    output logic             res_writeback,
    input  logic             wb_ack
);

    localparam int CNT_W      = cnt_bits(DIRTY_CHANCES);
    localparam int SCAN_BOUND = (DIRTY_CHANCES + 1) * NUM_FRAMES + 1;
    localparam int SL_W       = $clog2(SCAN_BOUND + 1);
    localparam logic [CNT_W:0] LIM_CLEAN = (CNT_W + 1)'(CLEAN_CHANCES);
    localparam logic [CNT_W:0] LIM_DIRTY = (CNT_W + 1)'(DIRTY_CHANCES);

    pick_state_e state_q, state_d;

    logic [IDX_W-1:0]            hand_q, hand_nxt, victim_q;
    logic                        wb_q;
    logic [NUM_FRAMES-1:0]       valid_vec, use_vec, dirty_vec;
    logic [NUM_FRAMES-1:0][CNT_W-1:0] cnt_vec;
    logic                        any_free;
    logic [IDX_W-1:0]            free_idx;
    logic                        use_h, dirty_h, pick_h;
    logic [CNT_W:0]              cnt_plus;
    logic                        exam_en, exam_clear, exam_inc, exam_zero, dclr_en;
    logic [SL_W-1:0]             scan_len_q;
    logic                        quiet_q;

    free_slot_pick #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_free (
        .valid_vec (valid_vec),
        .any_free  (any_free),
        .free_idx  (free_idx)
    );

    frame_meta_bank #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W),
        .CNT_MAX    (DIRTY_CHANCES)
    ) u_meta (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_valid  (ref_valid),
        .ref_frame  (ref_frame),
        .ref_write  (ref_write),
        .load_valid (load_valid),
        .load_frame (load_frame),
        .exam_en    (exam_en),
        .exam_frame (hand_q),
        .exam_clear (exam_clear),
        .exam_inc   (exam_inc),
        .exam_zero  (exam_zero),
        .dclr_en    (dclr_en),
        .dclr_frame (victim_q),
        .valid_vec  (valid_vec),
        .use_vec    (use_vec),
        .dirty_vec  (dirty_vec),
        .cnt_vec    (cnt_vec)
    );

    // Frame under the hand
    assign use_h    = use_vec[hand_q];
    assign dirty_h  = dirty_vec[hand_q];
    assign cnt_plus = {1'b0, cnt_vec[hand_q]} + 1'b1;
    assign pick_h   = !use_h && (cnt_plus >= (dirty_h ? LIM_DIRTY : LIM_CLEAN));
    assign hand_nxt = (hand_q == IDX_W'(NUM_FRAMES - 1)) ? '0 : hand_q + 1'b1;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (fault_req) state_d = any_free ? ST_REPORT : ST_SCAN;
            ST_SCAN:    if (pick_h)    state_d = ST_REPORT;
            ST_REPORT:  if (res_ready) state_d = wb_q ? ST_WB_WAIT : ST_IDLE;
            ST_WB_WAIT: if (wb_ack)    state_d = ST_IDLE;
        endcase
    end

    // Outputs and sweep controls
    always_comb begin
        res_valid     = (state_q == ST_REPORT);
        res_frame     = victim_q;
        res_writeback = wb_q;
        exam_en       = (state_q == ST_SCAN);
        exam_clear    = use_h;
        exam_inc      = !use_h && !pick_h;
        exam_zero     = pick_h;
        dclr_en       = (state_q == ST_WB_WAIT) && wb_ack;
    end

    // Hand, victim and search-length registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hand_q     <= '0;
            victim_q   <= '0;
            wb_q       <= 1'b0;
            scan_len_q <= '0;
            quiet_q    <= 1'b1;
        end else begin
            if (state_q == ST_IDLE) begin
                scan_len_q <= '0;
                quiet_q    <= 1'b1;
                if (fault_req && any_free) begin
                    victim_q <= free_idx;
                    wb_q     <= 1'b0;
                end
            end
            if (state_q == ST_SCAN) begin
                hand_q  <= hand_nxt;
                quiet_q <= quiet_q && !ref_valid && !load_valid;
                if (scan_len_q != SL_W'(SCAN_BOUND)) begin
                    scan_len_q <= scan_len_q + 1'b1;
                end
                if (pick_h) begin
                    victim_q <= hand_q;
                    wb_q     <= dirty_h;
                end
            end
        end
    end

    AST_HAND_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SCAN) |=> $stable(hand_q)) else $error("hand moved outside search"); // R5

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_frame) && $stable(res_writeback)))
        else $error("result changed before accept"); // R8

    AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WB_WAIT) && wb_ack && !(ref_valid && ref_write && ref_frame == victim_q))
        |=> !dirty_vec[$past(victim_q)]) else $error("dirty bit survived write-back"); // R7

    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SCAN) && quiet_q) |-> (scan_len_q < SL_W'(SCAN_BOUND)))
        else $error("search exceeded bound"); // R10

endmodule

// File: tb/clock_victim_picker_test.sv
module clock_victim_picker_test;

    localparam int NF = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_frame = '0;
    logic          ref_write = 1'b0;
    logic          load_valid = 1'b0;
    logic [IW-1:0] load_frame = '0;
    logic          fault_req = 1'b0;
    logic          res_valid;
    logic          res_ready = 1'b0;
    logic [IW-1:0] res_frame;
    logic          res_writeback;
    logic          wb_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    clock_victim_picker #(.NUM_FRAMES(NF)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_valid     (ref_valid),
        .ref_frame     (ref_frame),
        .ref_write     (ref_write),
        .load_valid    (load_valid),
        .load_frame    (load_frame),
        .fault_req     (fault_req),
        .res_valid     (res_valid),
        .res_ready     (res_ready),
        .res_frame     (res_frame),
        .res_writeback (res_writeback),
        .wb_ack        (wb_ack)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_frame_t(input int f);
        load_valid = 1'b1;
        load_frame = IW'(f);
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic touch(input int f, input bit wr);
        ref_valid = 1'b1;
        ref_frame = IW'(f);
        ref_write = wr;
        @(negedge clk);
        ref_valid = 1'b0;
        ref_write = 1'b0;
    endtask

    // Raise a fault; optionally reference frame rf when cycle count equals ref_at
    task automatic run_fault(input int ref_at, input int rf,
                             output int frame, output int wb, output int lat);
        int cyc = 0;
        fault_req = 1'b1;
        while (!res_valid && cyc < 100) begin
            if (cyc == ref_at) begin
                ref_valid = 1'b1;
                ref_frame = IW'(rf);
            end else begin
                ref_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        ref_valid = 1'b0;
        fault_req = 1'b0;
        frame = int'(res_frame);
        wb    = int'(res_writeback);
        lat   = cyc;
    endtask

    task automatic take_result(input int hold, input string req);
        int f0 = int'(res_frame);
        int w0 = int'(res_writeback);
        for (int k = 0; k < hold; k++) begin
            res_ready = 1'b0;
            @(negedge clk);
            chk(req, "held valid", int'(res_valid), 1);
            chk(req, "held frame", int'(res_frame), f0);
            chk(req, "held wb flag", int'(res_writeback), w0);
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(req, "valid dropped after accept", int'(res_valid), 0);
    endtask

    task automatic t_reset;
        chk("R1", "res_valid after reset", int'(res_valid), 0);
    endtask

    task automatic t_free_frames;
        int f, w, l;
        for (int i = 0; i < NF; i++) begin
            run_fault(-1, 0, f, w, l);
            chk("R2", "free frame index", f, i);
            chk("R2", "free frame wb flag", w, 0);
            chk("R2", "free frame latency", l, 1);
            take_result(0, "R2");
            load_frame_t(i);
        end
    endtask

    task automatic t_full_sweep;
        int f, w, l;
        // all frames referenced by loading: one full clear pass, then wrap to frame 0
        run_fault(-1, 0, f, w, l);
        chk("R5", "wrapped victim", f, 0);
        chk("R10", "sweep latency", l, NF + 2);
        chk("R10", "latency within bound", int'(l <= 3 * NF + 2), 1);
        take_result(0, "R5");
        load_frame_t(0);
        // hand now at 1, frame 1 unused: taken on first look
        run_fault(-1, 0, f, w, l);
        chk("R6", "hand after victim", f, 1);
        chk("R6", "one-look latency", l, 2);
        take_result(0, "R6");
        load_frame_t(1);
    endtask

    task automatic t_dirty_chance;
        int f, w, l;
        touch(2, 1'b1);
        touch(3, 1'b0);
        run_fault(-1, 0, f, w, l);
        chk("R6", "dirty frame skipped, clean taken", f, 3);
        chk("R6", "clean victim wb flag", w, 0);
        chk("R6", "latency with dirty skip", l, 7);
        take_result(0, "R6");
        load_frame_t(3);
        touch(0, 1'b0);
        touch(1, 1'b0);
        run_fault(-1, 0, f, w, l);
        chk("R4", "dirty frame victim on second chance", f, 2);
        chk("R7", "dirty victim wb flag", w, 1);
        chk("R6", "second-chance latency", l, 4);
        take_result(3, "R8");
        // waiting for write-back: a new fault must not be taken
        fault_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7", "no result before wb_ack", int'(res_valid), 0);
        fault_req = 1'b0;
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        @(negedge clk);
        chk("R7", "idle after wb_ack", int'(res_valid), 0);
        // frame 2 now clean: it goes after one unused pass
        touch(0, 1'b0);
        touch(1, 1'b0);
        run_fault(-1, 0, f, w, l);
        chk("R7", "cleaned frame taken as clean", f, 2);
        chk("R7", "cleaned frame wb flag", w, 0);
        chk("R7", "cleaned frame latency", l, 5);
        take_result(0, "R7");
    endtask

    task automatic t_ref_wins;
        int f, w, l;
        for (int i = 0; i < NF; i++) touch(i, 1'b0);
        // hand at 3; frame 0 is examined on the third edge, referenced on that edge
        run_fault(2, 0, f, w, l);
        chk("R9", "victim with concurrent reference", f, 3);
        chk("R9", "latency with concurrent reference", l, 6);
        take_result(0, "R9");
        run_fault(-1, 0, f, w, l);
        chk("R9", "referenced frame kept its use bit", f, 1);
        chk("R9", "latency after kept use bit", l, 3);
        take_result(0, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_free_frames();
        t_full_sweep();
        t_dirty_chance();
        t_ref_wins();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule